// File: doc/BRIEF.md
# Dual-Master Debug Mailbox

This block is a small register bank that a debug probe and the processor core share while the core is being debugged. The probe side reaches it through a shift-chain adapter that is already selected by the chip-level JTAG controller. The core side reaches it as memory-mapped registers. The probe drops data words into a receive slot that the core drains. It also writes instruction words into a command slot, and the block offers each one to the halted core through a valid/accept handshake.

Both masters use one access port. When both ask in the same cycle, the probe is served first. The core request is held off with a ready signal, and the core keeps its request stable until ready is seen high. A debug request pulse from the JTAG controller puts the block in halted mode, and command injection is allowed only in that mode. Writing the resume bit leaves halted mode and drops any command that has not been taken.

The address map uses a 2-bit address:
- 0 is the receive slot.
- 1 is the command slot.
- 2 is status, with bit0 receive-full, bit1 overrun (sticky), bit2 command-pending, bit3 command-error (sticky) and bit4 halted.
- 3 is control, where bit0 is resume on write and reads return 0.

Top module: `dbg_mailbox`

## Requirements
- R1: A probe-side access takes place only when both `jt_sel` and `jt_req` are high. Otherwise the probe inputs have no effect.
- R2: When both masters request in the same cycle, the probe access is performed and `cr_ready` is low. `cr_ready` goes high in the first cycle with no probe access, and the core access completes in that cycle.
- R3: A probe write to address 0 stores the word and sets status bit0. A core write to address 0 is ignored.
- R4: A core read of address 0 returns the stored word and clears status bit0. A probe write to address 0 while bit0 is set replaces the word and sets status bit1.
- R5: A `dbg_req` pulse sets `dbg_halt` and status bit4 from the next cycle on.
- R6: A write to address 1 while halted with no command pending raises `cmd_valid` on the next cycle, with `cmd_instr` equal to the written word. Both stay unchanged until accepted or resumed.
- R7: `cmd_accept` while `cmd_valid` is high clears `cmd_valid` on the next cycle. `cmd_accept` without `cmd_valid` has no effect.
- R8: A write to address 1 while a command is pending, or while not halted, leaves `cmd_instr` and `cmd_valid` unchanged and sets status bit3.
- R9: A write to address 3 with bit0 set clears `dbg_halt` and `cmd_valid` on the next cycle. A same-cycle `dbg_req` keeps the block halted.
- R10: Writing 1 to status bit1 or bit3 (address 2) clears that sticky bit. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| jt_sel | input | 1 | Bank selected by the chip JTAG controller |
| jt_req | input | 1 | Probe access strobe, one cycle per access |
| jt_we | input | 1 | Probe write (1) or read (0) |
| jt_addr | input | 2 | Probe register address |
| jt_wdata | input | DW | Probe write data |
| jt_rdata | output | DW | Probe read data, valid in the access cycle |
| cr_req | input | 1 | Core access valid |
| cr_we | input | 1 | Core write (1) or read (0) |
| cr_addr | input | 2 | Core register address |
| cr_wdata | input | DW | Core write data |
| cr_ready | output | 1 | Core access accepted this cycle |
| cr_rdata | output | DW | Core read data, valid when accepted |
| dbg_req | input | 1 | Enter halted mode (pulse) |
| dbg_halt | output | 1 | Core halted, injection enabled |
| cmd_valid | output | 1 | Injected instruction offered to the core |
| cmd_instr | output | DW | Injected instruction word |
| cmd_accept | input | 1 | Core takes the offered instruction (pulse) |

## Verification
The assertions rely on two assumptions about the core. First, it holds `cr_req` and its address and data steady until it sees `cr_ready`. Second, it pulses `cmd_accept` only for one cycle. The resume and hold properties also assume that `dbg_req` is never asserted in the same cycle as a resume write, except where R9 says otherwise. The stimulus issues each access as a one-cycle strobe on the probe side. It holds core requests until the handshake completes and never overlaps `dbg_req` with a resume. Each status value is read back through the normal register interface after every flag-changing step.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_AW = 2;

  typedef enum logic [MBX_AW-1:0] {
    ADR_RX   = 2'd0,
    ADR_CMD  = 2'd1,
    ADR_STAT = 2'd2,
    ADR_CTRL = 2'd3
  } mbx_addr_e;

  localparam int unsigned ST_FULL = 0;
  localparam int unsigned ST_OVR  = 1;
  localparam int unsigned ST_PEND = 2;
  localparam int unsigned ST_ERR  = 3;
  localparam int unsigned ST_DBG  = 4;
  localparam int unsigned ST_W    = 5;

  localparam int unsigned CTL_RESUME = 0;
endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              jt_sel,
  input  logic              jt_req,
  input  logic              jt_we,
  input  logic [MBX_AW-1:0] jt_addr,
  input  logic [DW-1:0]     jt_wdata,
  input  logic              cr_req,
  input  logic              cr_we,
  input  logic [MBX_AW-1:0] cr_addr,
  input  logic [DW-1:0]     cr_wdata,
  output logic              cr_ready,
  output logic              acc_vld,
  output logic              acc_jtag,
  output logic              acc_we,
  output logic [MBX_AW-1:0] acc_addr,
  output logic [DW-1:0]     acc_wdata
);
  logic jt_act;

  // Fixed priority: the probe wins any same-cycle contention.
  assign jt_act   = jt_sel & jt_req;
  assign cr_ready = ~jt_act;

  always_comb begin
    acc_vld   = jt_act | cr_req;
    acc_jtag  = jt_act;
    if (jt_act) begin
      acc_we    = jt_we;
      acc_addr  = jt_addr;
      acc_wdata = jt_wdata;
    end else begin
      acc_we    = cr_req & cr_we;
      acc_addr  = cr_addr;
      acc_wdata = cr_wdata;
    end
  end
endmodule

// File: rtl/mbx_rxbuf.sv
module mbx_rxbuf #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic          clr_ovr,
  output logic [DW-1:0] data,
  output logic          full,
  output logic          ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      full <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      if (wr) data <= wdata;
      if (wr)      full <= 1'b1;
      else if (rd) full <= 1'b0;
      if (wr && full)   ovr <= 1'b1;
      else if (clr_ovr) ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/mbx_cmdq.sv
module mbx_cmdq #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          accept,
  input  logic          resume,
  input  logic          dbg_req,
  input  logic          clr_err,
  output logic [DW-1:0] instr,
  output logic          pending,
  output logic          err,
  output logic          halted
);
  logic take;

  assign take = wr & halted & ~pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr   <= '0;
      pending <= 1'b0;
      err     <= 1'b0;
      halted  <= 1'b0;
    end else begin
      if (dbg_req)     halted <= 1'b1;
      else if (resume) halted <= 1'b0;

      if (resume)                 pending <= 1'b0;
      else if (take)              pending <= 1'b1;
      else if (accept && pending) pending <= 1'b0;

      if (take) instr <= wdata;

      if (wr && !take)  err <= 1'b1;
      else if (clr_err) err <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jt_sel,
  input  logic              jt_req,
  input  logic              jt_we,
  input  logic [MBX_AW-1:0] jt_addr,
  input  logic [DW-1:0]     jt_wdata,
  output logic [DW-1:0]     jt_rdata,
  input  logic              cr_req,
  input  logic              cr_we,
  input  logic [MBX_AW-1:0] cr_addr,
  input  logic [DW-1:0]     cr_wdata,
  output logic              cr_ready,
  output logic [DW-1:0]     cr_rdata,
  input  logic              dbg_req,
  output logic              dbg_halt,
  output logic              cmd_valid,
  output logic [DW-1:0]     cmd_instr,
  input  logic              cmd_accept
);
  logic              acc_vld, acc_jtag, acc_we;
  logic [MBX_AW-1:0] acc_addr;
  logic [DW-1:0]     acc_wdata;
  logic              wr_any, rd_any;
  logic              rx_wr, rx_rd, cmd_wr, stat_wr, ctrl_wr;
  logic [DW-1:0]     rx_data, rdata;
  logic              rx_full, rx_ovr, c_pend, c_err, c_halt;
  logic [ST_W-1:0]   status;

  mbx_arbiter #(.DW(DW)) u_arb (
    .jt_sel(jt_sel), .jt_req(jt_req), .jt_we(jt_we), .jt_addr(jt_addr),
    .jt_wdata(jt_wdata), .cr_req(cr_req), .cr_we(cr_we), .cr_addr(cr_addr),
    .cr_wdata(cr_wdata), .cr_ready(cr_ready), .acc_vld(acc_vld),
    .acc_jtag(acc_jtag), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata)
  );

  assign wr_any  = acc_vld & acc_we;
  assign rd_any  = acc_vld & ~acc_we;
  assign rx_wr   = wr_any & acc_jtag & (acc_addr == ADR_RX);
  assign rx_rd   = rd_any & ~acc_jtag & (acc_addr == ADR_RX);
  assign cmd_wr  = wr_any & (acc_addr == ADR_CMD);
  assign stat_wr = wr_any & (acc_addr == ADR_STAT);
  assign ctrl_wr = wr_any & (acc_addr == ADR_CTRL) & acc_wdata[CTL_RESUME];

  mbx_rxbuf #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .wr(rx_wr), .wdata(acc_wdata), .rd(rx_rd),
    .clr_ovr(stat_wr & acc_wdata[ST_OVR]), .data(rx_data), .full(rx_full),
    .ovr(rx_ovr)
  );

  mbx_cmdq #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(acc_wdata),
    .accept(cmd_accept), .resume(ctrl_wr), .dbg_req(dbg_req),
    .clr_err(stat_wr & acc_wdata[ST_ERR]), .instr(cmd_instr),
    .pending(c_pend), .err(c_err), .halted(c_halt)
  );

  always_comb begin
    status          = '0;
    status[ST_FULL] = rx_full;
    status[ST_OVR]  = rx_ovr;
    status[ST_PEND] = c_pend;
    status[ST_ERR]  = c_err;
    status[ST_DBG]  = c_halt;
  end

  always_comb begin
    rdata = '0;
    if (rd_any) begin
      unique case (acc_addr)
        ADR_RX:   rdata = rx_data;
        ADR_CMD:  rdata = cmd_instr;
        ADR_STAT: rdata = DW'(status);
        default:  rdata = '0;
      endcase
    end
  end

  assign jt_rdata  = acc_jtag ? rdata : '0;
  assign cr_rdata  = acc_jtag ? '0 : rdata;
  assign dbg_halt  = c_halt;
  assign cmd_valid = c_pend;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              jt_sel,
  input logic              jt_req,
  input logic              jt_we,
  input logic [MBX_AW-1:0] jt_addr,
  input logic [DW-1:0]     jt_wdata,
  input logic              cr_req,
  input logic              cr_we,
  input logic [MBX_AW-1:0] cr_addr,
  input logic [DW-1:0]     cr_wdata,
  input logic              cr_ready,
  input logic              dbg_req,
  input logic              dbg_halt,
  input logic              cmd_valid,
  input logic [DW-1:0]     cmd_instr,
  input logic              cmd_accept
);
  logic jt_on, resume_w;

  assign jt_on    = jt_sel & jt_req;
  assign resume_w = (jt_on & jt_we & (jt_addr == ADR_CTRL) & jt_wdata[CTL_RESUME])
                  | (cr_req & cr_ready & cr_we & (cr_addr == ADR_CTRL) & cr_wdata[CTL_RESUME]);

  a_r2_probe_first: assert property (@(posedge clk) disable iff (!rst_n)
    jt_on && cr_req |-> !cr_ready);

  a_r2_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cr_req && !jt_on |-> cr_ready);

  a_r5_enter_halt: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |=> dbg_halt);

  a_r6_cmd_needs_halt: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> dbg_halt);

  a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_accept && !resume_w |=> cmd_valid && $stable(cmd_instr));

  a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_accept && !resume_w |=> !cmd_valid);

  a_r9_resume: assert property (@(posedge clk) disable iff (!rst_n)
    resume_w && !dbg_req |=> !dbg_halt && !cmd_valid);
endmodule

bind dbg_mailbox mbx_checker #(.DW(DW)) u_chk (.*);

// File: tb/sim_dbg_mailbox.sv
`timescale 1ns/1ps
module sim_dbg_mailbox;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          jt_sel = 1'b0, jt_req = 1'b0, jt_we = 1'b0;
  logic [1:0]    jt_addr = '0;
  logic [DW-1:0] jt_wdata = '0;
  logic [DW-1:0] jt_rdata;
  logic          cr_req = 1'b0, cr_we = 1'b0;
  logic [1:0]    cr_addr = '0;
  logic [DW-1:0] cr_wdata = '0;
  logic          cr_ready;
  logic [DW-1:0] cr_rdata;
  logic          dbg_req = 1'b0, dbg_halt, cmd_valid, cmd_accept = 1'b0;
  logic [DW-1:0] cmd_instr;

  int tests = 0, fails = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  dbg_mailbox #(.DW(DW)) u0 (.*);

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expectation for every completed read.
  always @(negedge clk) begin
    if (rst_n) begin
      if (jt_sel && jt_req && !jt_we) begin
        if (exp_q.size() == 0) chk("scoreboard underflow", jt_rdata, '1);
        else chk(tag_q.pop_front(), jt_rdata, exp_q.pop_front());
      end
      if (cr_req && cr_ready && !cr_we) begin
        if (exp_q.size() == 0) chk("scoreboard underflow", cr_rdata, '1);
        else chk(tag_q.pop_front(), cr_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic jt_acc(logic sel, logic we, logic [1:0] a, logic [DW-1:0] d);
    jt_sel = sel; jt_req = 1'b1; jt_we = we; jt_addr = a; jt_wdata = d;
    @(posedge clk); #1;
    jt_sel = 1'b0; jt_req = 1'b0; jt_we = 1'b0;
  endtask

  task automatic jt_wr(logic [1:0] a, logic [DW-1:0] d);
    jt_acc(1'b1, 1'b1, a, d);
  endtask

  task automatic jt_rd(string tag, logic [1:0] a, logic [DW-1:0] exp);
    exp_q.push_back(exp); tag_q.push_back(tag);
    jt_acc(1'b1, 1'b0, a, '0);
  endtask

  task automatic cr_acc(logic we, logic [1:0] a, logic [DW-1:0] d);
    logic got;
    cr_req = 1'b1; cr_we = we; cr_addr = a; cr_wdata = d;
    do begin
      @(negedge clk); got = cr_ready;
      @(posedge clk); #1;
    end while (!got);
    cr_req = 1'b0; cr_we = 1'b0;
  endtask

  task automatic cr_rd(string tag, logic [1:0] a, logic [DW-1:0] exp);
    exp_q.push_back(exp); tag_q.push_back(tag);
    cr_acc(1'b0, a, '0);
  endtask

  task automatic pulse_accept();
    cmd_accept = 1'b1; @(posedge clk); #1; cmd_accept = 1'b0;
  endtask

  task automatic report();
    chk("scoreboard drained", DW'(exp_q.size()), '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // reset state
    chk("reset dbg_halt", DW'(dbg_halt), 0);
    chk("reset cmd_valid", DW'(cmd_valid), 0);
    jt_rd("reset status", 2'd2, 0);
    // R1: unselected probe write has no effect
    jt_acc(1'b0, 1'b1, 2'd0, 32'h11);
    jt_rd("R1 status", 2'd2, 0);
    jt_rd("R1 rx", 2'd0, 0);
    // R3: probe fills receive slot, core write ignored
    jt_wr(2'd0, 32'hA5);
    jt_rd("R3 status full", 2'd2, 32'h01);
    cr_acc(1'b1, 2'd0, 32'hFFFF);
    jt_rd("R3 core write ignored", 2'd0, 32'hA5);
    // R4: core drains, then overrun
    cr_rd("R4 core read", 2'd0, 32'hA5);
    jt_rd("R4 full cleared", 2'd2, 0);
    jt_wr(2'd0, 32'h1);
    jt_wr(2'd0, 32'h2);
    jt_rd("R4 overrun", 2'd2, 32'h03);
    jt_rd("R4 newest kept", 2'd0, 32'h2);
    // R10: clear overrun, control reads zero
    jt_wr(2'd2, 32'h2);
    jt_rd("R10 ovr cleared", 2'd2, 32'h01);
    cr_rd("R10 ctrl reads 0", 2'd3, 0);
    // R8: command while not halted
    cr_acc(1'b1, 2'd1, 32'h40);
    chk("R8 no cmd outside halt", DW'(cmd_valid), 0);
    jt_rd("R8 err set", 2'd2, 32'h09);
    cr_acc(1'b1, 2'd2, 32'h8);
    jt_rd("R10 err cleared", 2'd2, 32'h01);
    // R5: enter halted mode
    dbg_req = 1'b1; @(posedge clk); #1; dbg_req = 1'b0;
    chk("R5 dbg_halt", DW'(dbg_halt), 1);
    jt_rd("R5 status", 2'd2, 32'h11);
    // R6: inject command
    cr_acc(1'b1, 2'd1, 32'h1234);
    chk("R6 cmd_valid", DW'(cmd_valid), 1);
    chk("R6 cmd_instr", cmd_instr, 32'h1234);
    jt_rd("R6 status", 2'd2, 32'h15);
    // R8: write while pending
    jt_wr(2'd1, 32'h9999);
    chk("R8 instr kept", cmd_instr, 32'h1234);
    jt_rd("R8 status", 2'd2, 32'h1D);
    jt_wr(2'd2, 32'h8);
    // R7: accept
    pulse_accept();
    chk("R7 cleared", DW'(cmd_valid), 0);
    pulse_accept();
    jt_rd("R7 stray accept", 2'd2, 32'h11);
    // R2: same-cycle contention, probe overwrites full slot
    jt_sel = 1'b1; jt_req = 1'b1; jt_we = 1'b1; jt_addr = 2'd0; jt_wdata = 32'h77;
    cr_req = 1'b1; cr_we = 1'b0; cr_addr = 2'd0;
    exp_q.push_back(32'h77); tag_q.push_back("R2 deferred read");
    @(negedge clk); chk("R2 held off", DW'(cr_ready), 0);
    @(posedge clk); #1; jt_sel = 1'b0; jt_req = 1'b0; jt_we = 1'b0;
    @(negedge clk); chk("R2 granted", DW'(cr_ready), 1);
    @(posedge clk); #1; cr_req = 1'b0;
    jt_rd("R2 status", 2'd2, 32'h12);
    // R9: resume drops pending command
    jt_wr(2'd1, 32'hABC);
    chk("R9 cmd up", DW'(cmd_valid), 1);
    cr_acc(1'b1, 2'd3, 32'h1);
    chk("R9 halt off", DW'(dbg_halt), 0);
    chk("R9 cmd dropped", DW'(cmd_valid), 0);
    jt_rd("R9 status", 2'd2, 32'h02);
    repeat (2) @(posedge clk);
    report();
  end
endmodule